// File: doc/BRIEF.md
# Pilot-Correlating Channel Tap Estimator

This block estimates the first fifteen chip-spaced taps of a multipath channel in a direct-sequence receiver. While a packet's known pilot chips arrive, every finger multiplies a delayed copy of the received sample stream by the local spreading chip and accumulates the result. A second accumulator in each finger sums the same delayed samples without the spreading sign. The control unit marks where pilot correlation starts and where it stops with strobes.

On the stop strobe each finger combines its two sums into one normalized 8-bit estimate and latches it. A one-cycle valid pulse announces the new set. The estimates then stay unchanged while the rest of the packet is detected, until the next stop capture or a clear. The delay line shifts on every chip enable, whether or not a correlation is running. As a result the fingers hold real history as soon as a window opens.

Top module: `tap_estimator`

## Requirements
- R1: After reset all fifteen estimates are zero and `estValid` is low.
- R2: Finger f (f = 0..14) uses the input sample received f+1 chip enables earlier. The delay line advances one stage on every cycle with `chipEn` high, in every state.
- R3: Spreading chip code 0 means +1 and adds the delayed sample to the correlation sum. Code 1 means -1 and adds the negated sample. The raw sum always adds the delayed sample unchanged.
- R4: A start strobe zeroes both sums in every finger. Sums then grow on each later cycle with `chipEn` high, up to the stop cycle. Chips on the start cycle and on the stop cycle are not counted.
- R5: A stop strobe during accumulation raises `estValid` for exactly one cycle, in the cycle after the strobe. The estimate of finger f, (correlation + raw) shifted right by one with floor rounding, appears on `tapOut[8f+7:8f]` in that same cycle.
- R6: The normalized estimate saturates to the 8-bit signed range: values above 127 become 127 and values below -128 become -128.
- R7: Both sums are 16-bit two's-complement registers that wrap on overflow. Normalization adds the two wrapped 16-bit values.
- R8: Estimates hold their value until the next stop capture or clear. A stop strobe while no correlation is running has no effect and gives no valid pulse.
- R9: A clear strobe zeroes all estimates and sums, ends any correlation and gives no valid pulse. Clear overrides start and stop in the same cycle. Start overrides stop in the same cycle, which restarts the correlation without a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | One chip-rate sample is present this cycle |
| sampleIn | input | 8 | Signed received sample |
| spreadChip | input | 1 | Local spreading chip, 0 = +1, 1 = -1 |
| startPulse | input | 1 | Begin a pilot correlation window |
| stopPulse | input | 1 | End the window and capture estimates |
| clearPulse | input | 1 | Zero estimates and sums, abort window |
| tapOut | output | 120 | Fifteen signed 8-bit estimates, finger f at bits [8f+7:8f] |
| estValid | output | 1 | One-cycle pulse when a new estimate set is latched |

## Verification
A misaligned delay stage shows up at the ports only at the next capture: the impulse test gives each finger its own expected value, so a swapped or off-by-one stage changes specific bytes of `tapOut` in the cycle after stop. A sign or chip-decode fault in the correlator moves the estimate away from the sum of the positive-chip samples. Saturation and wrap errors show only once a long window has pushed a sum past its range. Control state faults, such as a window that stays open or a missed priority, appear within one cycle as a stray or missing `estValid` pulse, or as estimates that change while they should hold.

// File: rtl/tap_est_pkg.sv
package tap_est_pkg;

  // Strobes from control to datapath, valid in the cycle they are driven
  typedef struct packed {
    logic clrAcc;   // zero both sums in every finger
    logic accEn;    // add this chip's delayed sample into the sums
    logic capture;  // latch normalized estimates
    logic clrHold;  // zero latched estimates
  } estStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ACCUM = 1'b1
  } estState_t;

endpackage

// File: rtl/tap_est_ctrl.sv
module tap_est_ctrl
  import tap_est_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEn,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic       clearPulse,
  output estStrobe_t strobe,
  output logic       estValid
);

  estState_t state, stateNext;
  logic      accumulating;
  logic      validQ;

  assign accumulating = (state == ST_ACCUM);

  // Priority: clear over start over stop
  always_comb begin
    strobe.clrHold = clearPulse;
    strobe.clrAcc  = clearPulse | startPulse;
    strobe.capture = accumulating & stopPulse & ~clearPulse & ~startPulse;
    strobe.accEn   = accumulating & chipEn & ~clearPulse & ~startPulse & ~stopPulse;
  end

  always_comb begin
    stateNext = state;
    if (clearPulse)      stateNext = ST_IDLE;
    else if (startPulse) stateNext = ST_ACCUM;
    else if (stopPulse)  stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      validQ <= 1'b0;
    end else begin
      state  <= stateNext;
      validQ <= strobe.capture;
    end
  end

  assign estValid = validQ;

endmodule

// File: rtl/tap_est_finger.sv
module tap_est_finger
  import tap_est_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16,
  parameter int OUT_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  estStrobe_t                 strobe,
  input  logic signed [SAMPLE_W-1:0] sampleDly,
  input  logic                       chipNeg,
  output logic signed [OUT_W-1:0]    estOut
);

  localparam int PROD_W  = SAMPLE_W + 1;
  localparam int EXT_W   = ACC_W - PROD_W;
  localparam int OUT_MAX = (1 << (OUT_W - 1)) - 1;
  localparam int OUT_MIN = -(1 << (OUT_W - 1));

  logic signed [PROD_W-1:0] sampleExt, signedProd;
  logic signed [ACC_W-1:0]  prodAcc, rawAdd;
  logic signed [ACC_W-1:0]  corrAcc, rawAcc;
  logic signed [ACC_W:0]    sumWide, halfSum;
  logic signed [OUT_W-1:0]  satOut, holdReg;

  // Negate-or-pass selection replaces the multiply by +1/-1
  assign sampleExt  = {sampleDly[SAMPLE_W-1], sampleDly};
  assign signedProd = chipNeg ? -sampleExt : sampleExt;
  assign prodAcc    = {{EXT_W{signedProd[PROD_W-1]}}, signedProd};
  assign rawAdd     = {{(ACC_W-SAMPLE_W){sampleDly[SAMPLE_W-1]}}, sampleDly};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrAcc <= '0;
      rawAcc  <= '0;
    end else if (strobe.clrAcc) begin
      corrAcc <= '0;
      rawAcc  <= '0;
    end else if (strobe.accEn) begin
      corrAcc <= corrAcc + prodAcc;
      rawAcc  <= rawAcc + rawAdd;
    end
  end

  // Bias correction: keep the sum over +1 chips, then clip to output range
  assign sumWide = {corrAcc[ACC_W-1], corrAcc} + {rawAcc[ACC_W-1], rawAcc};
  assign halfSum = sumWide >>> 1;

  always_comb begin
    if (halfSum > $signed((ACC_W+1)'(OUT_MAX)))
      satOut = OUT_W'(OUT_MAX);
    else if (halfSum < $signed((ACC_W+1)'(OUT_MIN)))
      satOut = OUT_W'(OUT_MIN);
    else
      satOut = halfSum[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdReg <= '0;
    else if (strobe.clrHold) holdReg <= '0;
    else if (strobe.capture) holdReg <= satOut;
  end

  assign estOut = holdReg;

endmodule

// File: rtl/tap_est_datapath.sv
module tap_est_datapath
  import tap_est_pkg::*;
#(
  parameter int NUM_TAPS = 15,
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16,
  parameter int OUT_W    = 8,
  localparam int TAPS_W  = NUM_TAPS * OUT_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       chipEn,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       spreadChip,
  input  estStrobe_t                 strobe,
  output logic [TAPS_W-1:0]          tapOut
);

  logic signed [SAMPLE_W-1:0] hist [NUM_TAPS];

  // Sample history: stage s holds the sample from s+1 chip enables ago
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_TAPS; s++) hist[s] <= '0;
    end else if (chipEn) begin
      hist[0] <= sampleIn;
      for (int s = 1; s < NUM_TAPS; s++) hist[s] <= hist[s-1];
    end
  end

  for (genvar f = 0; f < NUM_TAPS; f++) begin : gFinger
    logic signed [OUT_W-1:0] est;
    tap_est_finger #(
      .SAMPLE_W(SAMPLE_W),
      .ACC_W   (ACC_W),
      .OUT_W   (OUT_W)
    ) uFinger (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .sampleDly(hist[f]),
      .chipNeg  (spreadChip),
      .estOut   (est)
    );
    assign tapOut[f*OUT_W +: OUT_W] = est;
  end

endmodule

// File: rtl/tap_estimator.sv
module tap_estimator
  import tap_est_pkg::*;
#(
  parameter int NUM_TAPS = 15,
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16,
  parameter int OUT_W    = 8,
  localparam int TAPS_W  = NUM_TAPS * OUT_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       chipEn,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       spreadChip,
  input  logic                       startPulse,
  input  logic                       stopPulse,
  input  logic                       clearPulse,
  output logic [TAPS_W-1:0]          tapOut,
  output logic                       estValid
);

  estStrobe_t strobe;

  tap_est_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipEn    (chipEn),
    .startPulse(startPulse),
    .stopPulse (stopPulse),
    .clearPulse(clearPulse),
    .strobe    (strobe),
    .estValid  (estValid)
  );

  tap_est_datapath #(
    .NUM_TAPS(NUM_TAPS),
    .SAMPLE_W(SAMPLE_W),
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .chipEn    (chipEn),
    .sampleIn  (sampleIn),
    .spreadChip(spreadChip),
    .strobe    (strobe),
    .tapOut    (tapOut)
  );

endmodule

// File: rtl/tap_est_chk.sv
module tap_est_chk #(
  parameter int TAPS_W = 120
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopPulse,
  input logic              clearPulse,
  input logic [TAPS_W-1:0] tapOut,
  input logic              estValid
);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    estValid |=> !estValid);

  // R5
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    estValid |-> $past(stopPulse));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopPulse && !clearPulse) |=> $stable(tapOut));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> (tapOut == '0) && !estValid);

endmodule

bind tap_estimator tap_est_chk #(.TAPS_W(TAPS_W)) uChk (.*);

// File: tb/sim_tap_estimator.sv
module sim_tap_estimator;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 15;

  logic              clk = 1'b0;
  logic              rstN;
  logic              chipEn, spreadChip, startPulse, stopPulse, clearPulse;
  logic signed [7:0] sampleIn;
  logic [NT*8-1:0]   tapOut;
  logic              estValid;

  int checks = 0, failures = 0;
  bit finished = 0;
  string curTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_estimator u0 (.*);

  // Behavioural reference model
  int  mHist [NT], mCorr [NT], mRaw [NT], mHold [NT];
  bit  mAcc, mValid;

  function automatic int w16(int v);
    shortint s;
    s = shortint'(v);
    return int'(s);
  endfunction

  function automatic int sat8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < NT; f++) begin
        mHist[f] = 0; mCorr[f] = 0; mRaw[f] = 0; mHold[f] = 0;
      end
      mAcc = 0; mValid = 0;
    end else begin
      mValid = 0;
      if (clearPulse) begin
        for (int f = 0; f < NT; f++) begin mCorr[f] = 0; mRaw[f] = 0; mHold[f] = 0; end
        mAcc = 0;
      end else if (startPulse) begin
        for (int f = 0; f < NT; f++) begin mCorr[f] = 0; mRaw[f] = 0; end
        mAcc = 1;
      end else if (stopPulse) begin
        if (mAcc) begin
          for (int f = 0; f < NT; f++) mHold[f] = sat8((mCorr[f] + mRaw[f]) >>> 1);
          mValid = 1;
        end
        mAcc = 0;
      end else if (mAcc && chipEn) begin
        for (int f = 0; f < NT; f++) begin
          mCorr[f] = w16(mCorr[f] + (spreadChip ? -mHist[f] : mHist[f]));
          mRaw[f]  = w16(mRaw[f] + mHist[f]);
        end
      end
      if (chipEn) begin
        for (int f = NT-1; f > 0; f--) mHist[f] = mHist[f-1];
        mHist[0] = int'(sampleIn);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [NT*8-1:0] act,
                       input logic [NT*8-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    logic [NT*8-1:0] expTaps;
    for (int f = 0; f < NT; f++) expTaps[f*8 +: 8] = 8'(mHold[f]);
    check(tapOut === expTaps, {curTag, " taps"}, tapOut, expTaps);
    check(estValid === mValid, {curTag, " estValid"}, {119'b0, estValid}, {119'b0, mValid});
  endtask

  // Drive at negedge, let one edge pass, compare at the next negedge
  task automatic step(input int s, input bit c, input bit e,
                      input bit st, input bit sp, input bit cl);
    sampleIn = 8'(s); spreadChip = c; chipEn = e;
    startPulse = st; stopPulse = sp; clearPulse = cl;
    @(posedge clk);
    @(negedge clk);
    compareModel();
  endtask

  task automatic fill(input int s, input int n);
    for (int i = 0; i < n; i++) step(s, 0, 1, 0, 0, 0);
  endtask

  task automatic expectAll(input logic [7:0] v, input string tag);
    logic [NT*8-1:0] e;
    e = {NT{v}};
    check(tapOut === e, tag, tapOut, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NT*8-1:0] e, snap;
    rstN = 0; sampleIn = 0; spreadChip = 0; chipEn = 0;
    startPulse = 0; stopPulse = 0; clearPulse = 0;
    repeat (3) @(negedge clk);
    curTag = "R1";
    check(tapOut === '0, "R1 reset taps", tapOut, '0);
    check(estValid === 1'b0, "R1 reset valid", {119'b0, estValid}, '0);
    rstN = 1;

    // R2: impulse through the delay line, alternating chips
    curTag = "R2";
    fill(0, 16);
    step(0, 0, 1, 1, 0, 0);
    for (int n = 0; n < 16; n++) step(n == 0 ? 50 : 0, n % 2, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0);
    for (int f = 0; f < NT; f++) e[f*8 +: 8] = (f % 2 == 1) ? 8'd50 : 8'd0;
    check(tapOut === e, "R2 per-finger delay", tapOut, e);
    check(estValid === 1'b1, "R5 valid after stop", {119'b0, estValid}, 1);
    step(0, 0, 1, 0, 0, 0);
    check(estValid === 1'b0, "R5 valid one cycle", {119'b0, estValid}, 0);

    // R3/R4: chip code 0 adds, 1 negates; start and stop chips not counted
    curTag = "R3 R4";
    fill(10, 20);
    step(10, 1, 1, 1, 0, 0);
    step(10, 0, 1, 0, 0, 0);
    step(10, 0, 1, 0, 0, 0);
    step(10, 0, 1, 0, 0, 0);
    step(10, 1, 1, 0, 0, 0);
    step(10, 1, 1, 0, 1, 0);
    expectAll(8'd30, "R3 R4 chip sign and window");

    // R7/R6: long window wraps the 16-bit sums, result clips low
    curTag = "R7";
    fill(127, 16);
    step(127, 0, 1, 1, 0, 0);
    for (int n = 0; n < 300; n++) step(127, 0, 1, 0, 0, 0);
    step(127, 0, 1, 0, 1, 0);
    expectAll(8'h80, "R7 wrapped sums");

    // R6: positive saturation
    curTag = "R6";
    fill(100, 16);
    step(100, 0, 1, 1, 0, 0);
    for (int n = 0; n < 10; n++) step(100, 0, 1, 0, 0, 0);
    step(100, 0, 1, 0, 1, 0);
    expectAll(8'h7f, "R6 positive clip");

    // R2/R3/R4/R6: random samples, chips and enable gaps
    curTag = "R2 R3 R4 R6 random";
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 16; i++) step(int'($urandom_range(255)) - 128, 0, 1, 0, 0, 0);
      step(int'($urandom_range(255)) - 128, 0, 1, 1, 0, 0);
      for (int n = 0; n < 40 + 10 * r; n++)
        step(int'($urandom_range(255)) - 128, 1'($urandom_range(1)),
             $urandom_range(9) < 7, 0, 0, 0);
      step(0, 0, 1, 0, 1, 0);
    end

    // R8: hold across samples; stop while idle ignored
    curTag = "R8";
    snap = tapOut;
    for (int n = 0; n < 20; n++) step(int'($urandom_range(255)) - 128, 1'($urandom_range(1)), 1, 0, 0, 0);
    check(tapOut === snap, "R8 hold", tapOut, snap);
    step(5, 0, 1, 0, 1, 0);
    check(tapOut === snap, "R8 idle stop taps", tapOut, snap);
    check(estValid === 1'b0, "R8 idle stop valid", {119'b0, estValid}, 0);

    // R9: clear beats start and stop; then window is closed
    curTag = "R9";
    step(3, 0, 1, 1, 0, 0);
    for (int n = 0; n < 5; n++) step(7, 0, 1, 0, 0, 0);
    step(7, 0, 1, 1, 1, 1);
    expectAll(8'h00, "R9 clear zeroes taps");
    check(estValid === 1'b0, "R9 no valid on clear", {119'b0, estValid}, 0);
    step(7, 0, 1, 0, 1, 0);
    check(estValid === 1'b0, "R9 window closed", {119'b0, estValid}, 0);
    // start beats stop: restart, no capture
    fill(4, 16);
    step(4, 0, 1, 1, 0, 0);
    for (int n = 0; n < 5; n++) step(4, 0, 1, 0, 0, 0);
    step(4, 0, 1, 1, 1, 0);
    check(estValid === 1'b0, "R9 start over stop", {119'b0, estValid}, 0);
    for (int n = 0; n < 3; n++) step(4, 0, 1, 0, 0, 0);
    step(4, 0, 1, 0, 1, 0);
    expectAll(8'd12, "R9 restarted window");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule